// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a register-mapped watchdog for a chipset management interface. Firmware loads a timer initial value, clears a halt bit to arm the countdown, and must write the reload register regularly. The count drops by one on each cycle where an external slow tick enable is high. A first expiry flags a timeout, raises either a system-management interrupt or a non-maskable interrupt, then reloads and keeps counting. A second expiry in a row escalates. It records boot status and asks for a system reset, unless a speaker strap input or a no-reboot input blocks the reset.

The register file also holds two byte mailboxes, two status words, two control words, two message bytes, a watchdog-count byte, a software-interrupt byte and an SMI routing enable word. A lock bit in control word 1 can be set once per reset. While it is set, the watchdog bit of the SMI routing word is frozen. Accesses use a word index, a 16-bit data bus and two byte-lane enables. Byte lane 0 is bits 7:0 and lane 1 is bits 15:8. Reads are combinational.

Top module: `wdog_escalate`

Word index map: 0 reload, 1 initial value, 2 data-in, 3 data-out, 4 status 1, 5 status 2, 6 control 1, 7 control 2, 8 messages, 9 watchdog count, 10 software interrupt, 11 SMI routing. Control 1 bit 11 is halt and bit 12 is lock. Status 1 uses bit 1 for software SMI, bit 2 for interrupt status and bit 3 for timeout. Status 2 uses bit 1 for second timeout and bit 2 for boot status. SMI routing bit 13 is the watchdog enable. The count field is the low CNT_W (10) bits.

## Requirements
- R1: After reset, the initial value reads 4, control 2 reads 0x0008, the software-interrupt register reads 0x0003, and every other register reads 0. The timer is stopped and all pulse outputs are low.
- R2: The countdown can start only if halt (control 1 bit 11) is clear and the initial value is greater than 1. Initial values 0 and 1 never start it.
- R3: Any write to the reload register clears the consecutive-timeout counter. If the timer may run, the write restarts the count from the initial value. Otherwise the written data is stored unchanged.
- R4: A write to control 1 restarts the count from the initial value when the run condition holds, and stops the timer when it does not.
- R5: The lock bit (control 1 bit 12) can be set by software but not cleared. Only reset clears it.
- R6: While lock is set, SMI routing bit 13 keeps its value on writes, and the other bits of that register take the written data.
- R7: An expiry occurs on the tick that arrives when the remaining count is 1 or less. An armed timer with initial value N therefore expires after N ticks. The expiry sets status 1 bit 3 and reloads the count. It raises smi_pulse if SMI routing bit 13 is set, and nmi_pulse otherwise. Each pulse lasts one cycle and appears in the cycle after the causing edge.
- R8: On the second consecutive expiry, status 2 bits 1 and 2 are set and the counter clears. If strap_spkr and no_reboot are both low, reset_req pulses for one cycle, the timer stops, the reload register reads 0, and no SMI or NMI is raised. Otherwise the interrupt of R7 is raised and counting continues.
- R9: A write to data-in stores the low byte, sets status 1 bit 1 and pulses smi_pulse. A write to data-out stores the low byte and sets status 1 bit 2, with no pulse.
- R10: While the timer runs, a read of the reload register returns the remaining count in the low CNT_W bits. While the timer is stopped, the read returns the stored value.
- R11: byte_en selects which byte lanes a write updates, and a lane that is not enabled keeps its old contents.
- R12: A write to a status word replaces the writable bits with the data, so writing zeros clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle countdown tick |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register word index |
| byte_en | input | 2 | Byte lane enables for writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr |
| strap_spkr | input | 1 | Strap: high blocks the reset |
| no_reboot | input | 1 | High blocks the reset |
| smi_pulse | output | 1 | SMI request pulse |
| nmi_pulse | output | 1 | NMI request pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
The hardest state to reach is two consecutive expiries under each combination of the reset-blocking inputs. Reaching it also requires that the hidden consecutive-timeout counter is known at each point. The bench walks a small initial value of 3 through repeated expiries. It holds strap_spkr high, then no_reboot high, then both low. It starts each sequence right after a counter-clearing event: a reset-producing second expiry or a reload write. This lets the expected interrupt, the expected reset and the status bits be predicted from the tick count alone. Run eligibility is swept over initial values 0 to 5 with halt clear and with halt set.

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int CNT_W = 10,
  parameter int TMR_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [1:0]  byte_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        strap_spkr,
  input  logic        no_reboot,
  output logic        smi_pulse,
  output logic        nmi_pulse,
  output logic        reset_req
);
  localparam logic [3:0] A_RLD = 4'd0, A_TMR = 4'd1, A_DIN = 4'd2, A_DOUT = 4'd3,
                         A_ST1 = 4'd4, A_ST2 = 4'd5, A_CT1 = 4'd6, A_CT2 = 4'd7,
                         A_MSG = 4'd8, A_WDC = 4'd9, A_SWI = 4'd10, A_SMIE = 4'd11;
  localparam int HALT = 11, LOCK = 12, WDEN = 13;
  localparam int TO_B = 3, SWSMI_B = 1, INT_B = 2, SEC_B = 1, BOOT_B = 2;
  localparam logic [15:0] CMASK = 16'((32'd1 << CNT_W) - 1);
  localparam logic [15:0] ST1_WM = 16'h000E;
  localparam logic [15:0] ST2_WM = 16'h0006;
  localparam logic [15:0] CT1_WM = 16'h1F00;

  logic [15:0] rld_q, tmr_q, sts1_q, sts2_q, ctrl1_q, ctrl2_q, msg_q, smien_q;
  logic [7:0]  din_q, dout_q, wdc_q, swi_q;
  logic [CNT_W-1:0] cnt_q;
  logic run_q, to_q;

  function automatic logic [15:0] lanes(input logic [15:0] o, input logic [15:0] d,
                                        input logic [1:0] be);
    return {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
  endfunction

  function automatic logic [7:0] lane0(input logic [7:0] o, input logic [15:0] d,
                                       input logic [1:0] be);
    return be[0] ? d[7:0] : o;
  endfunction

  wire wr_any = wr_en && (byte_en != 2'b00);
  wire w_rld  = wr_any && addr == A_RLD;
  wire w_din  = wr_any && addr == A_DIN;
  wire w_dout = wr_any && addr == A_DOUT;
  wire w_ct1  = wr_any && addr == A_CT1;

  wire [15:0] rld_w  = lanes(rld_q, wr_data, byte_en);
  wire [15:0] tmr_w  = lanes(tmr_q, wr_data, byte_en) & CMASK;
  wire [15:0] ct1_w  = (lanes(ctrl1_q, wr_data, byte_en) & CT1_WM) | (ctrl1_q & (16'd1 << LOCK));
  wire [15:0] smie_m = lanes(smien_q, wr_data, byte_en);
  wire [15:0] smie_w = ctrl1_q[LOCK] ? {smie_m[15:WDEN+1], smien_q[WDEN], smie_m[WDEN-1:0]} : smie_m;

  wire tmr_ok   = tmr_q > 16'd1;
  wire can_run  = !ctrl1_q[HALT] && tmr_ok;
  wire run_new  = !ct1_w[HALT] && tmr_ok;
  wire expire   = run_q && tick_en && (cnt_q <= CNT_W'(1));
  wire do_reset = expire && to_q && !strap_spkr && !no_reboot;
  wire irq_fire = expire && !do_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0; tmr_q <= 16'(TMR_RST); sts1_q <= '0; sts2_q <= '0;
      ctrl1_q <= '0; ctrl2_q <= 16'h0008; msg_q <= '0; smien_q <= '0;
      din_q <= '0; dout_q <= '0; wdc_q <= '0; swi_q <= 8'h03;
      cnt_q <= '0; run_q <= 1'b0; to_q <= 1'b0;
      smi_pulse <= 1'b0; nmi_pulse <= 1'b0; reset_req <= 1'b0;
    end else begin
      smi_pulse <= (irq_fire && smien_q[WDEN]) || w_din;
      nmi_pulse <= irq_fire && !smien_q[WDEN];
      reset_req <= do_reset;

      if (wr_any) begin
        case (addr)
          A_TMR:  tmr_q   <= tmr_w;
          A_DIN:  din_q   <= lane0(din_q, wr_data, byte_en);
          A_DOUT: dout_q  <= lane0(dout_q, wr_data, byte_en);
          A_CT2:  ctrl2_q <= lanes(ctrl2_q, wr_data, byte_en);
          A_MSG:  msg_q   <= lanes(msg_q, wr_data, byte_en);
          A_WDC:  wdc_q   <= lane0(wdc_q, wr_data, byte_en);
          A_SWI:  swi_q   <= lane0(swi_q, wr_data, byte_en);
          A_SMIE: smien_q <= smie_w;
          default: ;
        endcase
      end

      sts1_q <= ((wr_any && addr == A_ST1) ? lanes(sts1_q, wr_data, byte_en) & ST1_WM : sts1_q)
              | (16'(expire) << TO_B) | (16'(w_din) << SWSMI_B) | (16'(w_dout) << INT_B);
      sts2_q <= ((wr_any && addr == A_ST2) ? lanes(sts2_q, wr_data, byte_en) & ST2_WM : sts2_q)
              | (16'(expire && to_q) << SEC_B) | (16'(expire && to_q) << BOOT_B);

      if (expire) begin
        to_q  <= !to_q;
        cnt_q <= tmr_q[CNT_W-1:0];
        if (do_reset) begin
          run_q <= 1'b0;
          rld_q <= '0;
        end else begin
          rld_q <= tmr_q;
        end
      end else if (run_q && tick_en) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end

      if (w_rld) begin
        to_q <= 1'b0;
        if (can_run) begin
          rld_q <= tmr_q;
          cnt_q <= tmr_q[CNT_W-1:0];
          run_q <= 1'b1;
        end else begin
          rld_q <= rld_w;
        end
      end

      if (w_ct1) begin
        ctrl1_q <= ct1_w;
        if (run_new) begin
          rld_q <= tmr_q;
          cnt_q <= tmr_q[CNT_W-1:0];
          run_q <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_RLD:  rd_data = run_q ? ((rld_q & ~CMASK) | 16'(cnt_q)) : rld_q;
      A_TMR:  rd_data = tmr_q;
      A_DIN:  rd_data = {8'h00, din_q};
      A_DOUT: rd_data = {8'h00, dout_q};
      A_ST1:  rd_data = sts1_q;
      A_ST2:  rd_data = sts2_q;
      A_CT1:  rd_data = ctrl1_q;
      A_CT2:  rd_data = ctrl2_q;
      A_MSG:  rd_data = msg_q;
      A_WDC:  rd_data = {8'h00, wdc_q};
      A_SWI:  rd_data = {8'h00, swi_q};
      A_SMIE: rd_data = smien_q;
      default: rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic lock,
  input logic wd_en,
  input logic boot,
  input logic nmi,
  input logic rst_req
);
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock);
  // R6
  wden_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) lock |=> $stable(wd_en));
  // R8
  reset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(nmi && rst_req));
  // R8
  reset_boot_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> boot);
  // R8
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req);
  // R7
  nmi_running_chk: assert property (@(posedge clk) disable iff (!rst_n) nmi |-> $past(run));
endmodule

bind wdog_escalate wdog_escalate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .lock(ctrl1_q[12]), .wd_en(smien_q[13]),
  .boot(sts2_q[2]), .nmi(nmi_pulse), .rst_req(reset_req)
);

// File: tb/wdog_escalate_bench.sv
module wdog_escalate_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] byte_en = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic strap_spkr = 1'b0, no_reboot = 1'b0;
  logic smi_pulse, nmi_pulse, reset_req;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_escalate u_wdog_escalate (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk); addr = a; wr_data = d; byte_en = be; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; byte_en = 2'b00;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1; chk(tag, rd_data, exp);
  endtask

  task automatic tk();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic pulses(input logic s, input logic n, input logic r, input string tag);
    chk(tag, {13'd0, s, n, r}, {13'd0, smi_pulse, nmi_pulse, reset_req});
  endtask

  task automatic quiet_ticks(input int k, input string tag);
    for (int i = 0; i < k; i++) begin tk(); pulses(0, 0, 0, tag); end
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 12; a++) begin
      logic [15:0] e;
      e = (a == 1) ? 16'd4 : (a == 7) ? 16'h0008 : (a == 10) ? 16'h0003 : 16'h0000;
      rd(4'(a), e, "R1 reset value");
    end
    pulses(0, 0, 0, "R1 pulses idle");

    wr(4'd8, 16'h1234, 2'b01); rd(4'd8, 16'h0034, "R11 low lane");
    wr(4'd8, 16'hAB00, 2'b10); rd(4'd8, 16'hAB34, "R11 high lane");

    wr(4'd2, 16'hFF5A); pulses(1, 0, 0, "R9 din smi");
    @(negedge clk); pulses(0, 0, 0, "R9 smi one cycle");
    rd(4'd2, 16'h005A, "R9 din stored"); rd(4'd4, 16'h0002, "R9 swsmi flag");
    wr(4'd3, 16'h0077); pulses(0, 0, 0, "R9 dout no pulse");
    rd(4'd3, 16'h0077, "R9 dout stored"); rd(4'd4, 16'h0006, "R9 int flag");
    wr(4'd4, 16'h0000); rd(4'd4, 16'h0000, "R12 status cleared");

    for (int t = 0; t < 6; t++) begin
      wr(4'd6, 16'h0800); wr(4'd0, 16'hA000); wr(4'd1, 16'(t));
      rd(4'd0, 16'hA000, "R3 stored while halted");
      tk(); rd(4'd0, 16'hA000, "R2 halted no count");
      wr(4'd6, 16'h0000);
      rd(4'd0, (t > 1) ? 16'(t) : 16'hA000, "R2 start");
      tk(); pulses(0, 0, 0, "R2 no early expiry");
      rd(4'd0, (t > 1) ? 16'(t - 1) : 16'hA000, "R10 remaining");
    end

    wr(4'd6, 16'h0800); wr(4'd1, 16'd3); wr(4'd4, 0); wr(4'd5, 0);
    wr(4'd0, 16'h0000);
    wr(4'd6, 16'h0000);
    quiet_ticks(2, "R7 before expiry"); rd(4'd0, 16'd1, "R10 count 1");
    tk(); pulses(0, 1, 0, "R7 first expiry nmi");
    @(negedge clk); pulses(0, 0, 0, "R7 nmi one cycle");
    rd(4'd4, 16'h0008, "R7 timeout flag"); rd(4'd0, 16'd3, "R7 reloaded");
    quiet_ticks(2, "R8 wait");
    tk(); pulses(0, 0, 1, "R8 second expiry reset");
    rd(4'd5, 16'h0006, "R8 status2"); rd(4'd0, 16'h0000, "R8 stopped reads 0");
    quiet_ticks(5, "R8 stopped after reset");

    wr(4'd5, 0); strap_spkr = 1'b1; wr(4'd6, 16'h0000);
    quiet_ticks(2, "R8 strap"); tk(); pulses(0, 1, 0, "R8 strap first");
    quiet_ticks(2, "R8 strap"); tk(); pulses(0, 1, 0, "R8 strap blocks reset");
    rd(4'd5, 16'h0006, "R8 strap status2");
    strap_spkr = 1'b0;
    quiet_ticks(2, "R8 counter cleared"); tk(); pulses(0, 1, 0, "R8 counter cleared first");
    no_reboot = 1'b1;
    quiet_ticks(2, "R8 noreboot"); tk(); pulses(0, 1, 0, "R8 noreboot blocks reset");
    no_reboot = 1'b0;

    wr(4'd6, 16'h0000);
    quiet_ticks(2, "R3 run"); tk(); pulses(0, 1, 0, "R3 first");
    wr(4'd0, 16'h0000);
    quiet_ticks(2, "R3 run"); tk(); pulses(0, 1, 0, "R3 counter cleared by reload");
    quiet_ticks(2, "R3 run"); tk(); pulses(0, 0, 1, "R3 then second");

    wr(4'd6, 16'h0000); tk(); wr(4'd6, 16'h0800);
    rd(4'd0, 16'd3, "R4 halt stops");
    quiet_ticks(6, "R4 halted quiet");

    wr(4'd11, 16'h2000); rd(4'd11, 16'h2000, "R6 unlocked write");
    wr(4'd6, 16'h0000);
    quiet_ticks(2, "R7 smi route"); tk(); pulses(1, 0, 0, "R7 smi routed");
    wr(4'd6, 16'h1000); rd(4'd6, 16'h1000, "R5 lock set");
    wr(4'd6, 16'h0000); rd(4'd6, 16'h1000, "R5 lock sticky");
    wr(4'd11, 16'h00FF); rd(4'd11, 16'h20FF, "R6 locked bit kept");
    wr(4'd11, 16'hC000); rd(4'd11, 16'hE000, "R6 other bits update");

    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(4'd6, 16'h0000, "R5 reset clears lock");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule